// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches three external interrupt pins and turns activity on them into one interrupt request per channel. Each pin goes through a clocked synchroniser. A register then keeps the previous synchronised sample, and edges are found by comparing the two. Channels 0 and 1 each take a two-bit sense mode: low level, any change, falling edge or rising edge. Channel 2 senses edges only. Its one select bit picks the falling or the rising edge.

Detected edges set a sticky flag per channel. The flag stays set until a clear strobe or an acknowledge removes it. Low-level sensing sets no flag: the request follows the synchronised pin and stays up only while the pin is held low. A request leaves the block only when the global enable and the channel's mask bit are both set. Sensing uses the pin value alone, so logic that drives the pin as an output can raise an interrupt from software. The request outputs feed an interrupt controller outside this block.

Top module: `eint_sense_ctrl`

## Requirements
- R1: While reset is high, and on the first clock after it, every flag and every request is 0. A pin held high through reset produces no edge.
- R2: A pin change passes through two synchroniser registers. In an edge mode, the flag rises on the third rising clock edge after the pin changes.
- R3: Channel 0 or 1 with mode 2'b00 (low level) asserts its request on the third clock edge after the pin goes low. The request drops on the third edge after the pin returns high. This mode never sets the flag, and a clear or acknowledge has no effect on the request.
- R4: Mode 2'b01 (any change) sets the flag on both rising and falling pin transitions.
- R5: Mode 2'b10 sets the flag only on falling transitions. Mode 2'b11 sets it only on rising transitions.
- R6: Channel 2 has one select bit: 0 selects the falling edge and 1 selects the rising edge. This channel has no level mode.
- R7: In an edge mode, the request is registered one cycle after the flag and equals global enable AND mask bit AND flag. A change of the enable or the mask reaches the request on the next clock edge.
- R8: A flag clears on the clock edge after a clear strobe or an acknowledge. If a detected edge arrives in the same cycle, the edge wins and the flag stays set.
- R9: In a cycle where a channel's sense mode differs from its value one cycle earlier, edge detection is suppressed for that channel and the previous-sample register is refreshed.
- R10: A pulse that lasts one full clock period is captured. It sets the flag if its edge matches the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 3 | Raw interrupt pins, channel n on bit n |
| mode0_i | input | 2 | Channel 0 sense mode (00 low, 01 any, 10 fall, 11 rise) |
| mode1_i | input | 2 | Channel 1 sense mode, same encoding |
| edge2_i | input | 1 | Channel 2 edge select (0 fall, 1 rise) |
| mask_i | input | 3 | Per-channel request mask |
| gie_i | input | 1 | Global interrupt enable |
| flag_clr_i | input | 3 | Per-channel flag clear strobe |
| ack_i | input | 3 | Per-channel acknowledge, also clears the flag |
| flag_o | output | 3 | Sticky edge flags |
| irq_o | output | 3 | Gated per-channel interrupt requests |

## Verification
Every result has a fixed latency counted from the clock edge that first samples a stimulus. An edge flag appears on the third edge and its request on the fourth. A level request appears or disappears on the third edge. A clear, an acknowledge or a change of enable or mask takes effect on the next edge. The bench drives inputs on falling clock edges and samples outputs on falling edges. Each directed check waits exactly the number of cycles its latency gives. A cycle-level reference model, built from these latencies, is compared with both outputs on every falling edge during the random phase. The mode-change check switches the mode in the exact cycle in which the synchronised edge becomes visible.

// File: rtl/eint_pkg.sv
package eint_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam int unsigned NUM_CH = 3;
endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{RST_VAL}};
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/eint_chan.sv
module eint_chan
  import eint_pkg::*;
#(
  parameter bit   EDGE_ONLY = 1'b0,
  parameter logic IDLE_VAL  = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sync_i,
  input  logic [1:0] mode_i,
  input  logic       en_i,
  input  logic       clr_i,
  input  logic       ack_i,
  output logic       edge_o,
  output logic       flag_o,
  output logic       irq_o
);
  sense_e mode_eff;
  sense_e mode_q;
  logic   prev_q;
  logic   flag_q;
  logic   irq_q;
  logic   mode_chg;
  logic   hit;

  generate
    if (EDGE_ONLY) begin : g_edge_only
      assign mode_eff = sense_e'({1'b1, mode_i[0]});
    end else begin : g_full
      assign mode_eff = sense_e'(mode_i);
    end
  endgenerate

  assign mode_chg = (mode_eff != mode_q);

  always_comb begin
    hit = 1'b0;
    if (!mode_chg) begin
      unique case (mode_eff)
        SENSE_LOW:  hit = 1'b0;
        SENSE_ANY:  hit = sync_i ^ prev_q;
        SENSE_FALL: hit = prev_q & ~sync_i;
        SENSE_RISE: hit = sync_i & ~prev_q;
        default:    hit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    mode_q <= mode_eff;
    if (rst) begin
      prev_q <= IDLE_VAL;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= sync_i;
      if (hit)                flag_q <= 1'b1;
      else if (clr_i | ack_i) flag_q <= 1'b0;
      if (mode_eff == SENSE_LOW) irq_q <= en_i & ~sync_i;
      else                       irq_q <= en_i & flag_q;
    end
  end

  assign edge_o = hit;
  assign flag_o = flag_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/eint_sense_ctrl.sv
module eint_sense_ctrl
  import eint_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic        PIN_IDLE    = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] pin_i,
  input  logic [1:0] mode0_i,
  input  logic [1:0] mode1_i,
  input  logic       edge2_i,
  input  logic [2:0] mask_i,
  input  logic       gie_i,
  input  logic [2:0] flag_clr_i,
  input  logic [2:0] ack_i,
  output logic [2:0] flag_o,
  output logic [2:0] irq_o
);
  localparam int unsigned LAST_CH = NUM_CH - 1;

  logic [NUM_CH-1:0] pin_sync;
  logic [NUM_CH-1:0] edge_hit;
  logic [1:0]        mode_arr [NUM_CH];

  assign mode_arr[0] = mode0_i;
  assign mode_arr[1] = mode1_i;
  assign mode_arr[2] = {1'b1, edge2_i};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    eint_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_IDLE)
    ) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i (pin_i[c]),
      .q_o (pin_sync[c])
    );

    eint_chan #(
      .EDGE_ONLY (c == LAST_CH),
      .IDLE_VAL  (PIN_IDLE)
    ) u_chan (
      .clk    (clk),
      .rst    (rst),
      .sync_i (pin_sync[c]),
      .mode_i (mode_arr[c]),
      .en_i   (gie_i & mask_i[c]),
      .clr_i  (flag_clr_i[c]),
      .ack_i  (ack_i[c]),
      .edge_o (edge_hit[c]),
      .flag_o (flag_o[c]),
      .irq_o  (irq_o[c])
    );
  end
endmodule

// File: rtl/eint_sense_chk.sv
module eint_sense_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode0_i,
  input logic [1:0] mode1_i,
  input logic       edge2_i,
  input logic [2:0] mask_i,
  input logic       gie_i,
  input logic [2:0] flag_clr_i,
  input logic [2:0] ack_i,
  input logic [2:0] flag_o,
  input logic [2:0] irq_o,
  input logic [2:0] pin_sync,
  input logic [2:0] edge_hit
);
  logic [1:0] mv [3];
  assign mv[0] = mode0_i;
  assign mv[1] = mode1_i;
  assign mv[2] = {1'b1, edge2_i};

  for (genvar c = 0; c < 3; c++) begin : g_a
    assert_edge_sets_flag_R2: assert property (@(posedge clk) disable iff (rst)
      edge_hit[c] |=> flag_o[c]);
    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (rst)
      (!edge_hit[c] && (flag_clr_i[c] || ack_i[c])) |=> !flag_o[c]);
    assert_gated_req_R7: assert property (@(posedge clk) disable iff (rst)
      irq_o[c] |-> $past(gie_i && mask_i[c]));
    assert_mode_change_quiet_R9: assert property (@(posedge clk) disable iff (rst)
      (mv[c] != $past(mv[c])) |-> !edge_hit[c]);
  end

  for (genvar c = 0; c < 2; c++) begin : g_lvl
    assert_level_req_R3: assert property (@(posedge clk) disable iff (rst)
      (mv[c] == 2'b00 && gie_i && mask_i[c] && !pin_sync[c]) |=> irq_o[c]);
    assert_level_no_flag_R3: assert property (@(posedge clk) disable iff (rst)
      (mv[c] == 2'b00 && !flag_o[c]) |=> !flag_o[c]);
  end

  assert_ch2_polarity_R6: assert property (@(posedge clk) disable iff (rst)
    edge_hit[2] |-> (pin_sync[2] == edge2_i));
endmodule

bind eint_sense_ctrl eint_sense_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode0_i    (mode0_i),
  .mode1_i    (mode1_i),
  .edge2_i    (edge2_i),
  .mask_i     (mask_i),
  .gie_i      (gie_i),
  .flag_clr_i (flag_clr_i),
  .ack_i      (ack_i),
  .flag_o     (flag_o),
  .irq_o      (irq_o),
  .pin_sync   (pin_sync),
  .edge_hit   (edge_hit)
);

// File: tb/tb_eint_sense_ctrl.sv
`timescale 1ns/1ps
module tb_eint_sense_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] pin;
  logic [1:0] mode0, mode1;
  logic       edge2;
  logic [2:0] mask, clr, ack;
  logic       gie;
  logic [2:0] flag_o, irq_o;

  int checks = 0;
  int fails  = 0;
  bit run    = 1'b0;

  always #2 clk = ~clk;

  eint_sense_ctrl dut (
    .clk(clk), .rst(rst), .pin_i(pin), .mode0_i(mode0), .mode1_i(mode1),
    .edge2_i(edge2), .mask_i(mask), .gie_i(gie), .flag_clr_i(clr),
    .ack_i(ack), .flag_o(flag_o), .irq_o(irq_o)
  );

  // Reference model built from the stated latencies
  logic [2:0] m_s1, m_s2, m_pv, m_flag, m_irq;
  logic [1:0] m_mq [3];

  function automatic logic [1:0] mode_of(input int c);
    if (c == 0) return mode0;
    if (c == 1) return mode1;
    return {1'b1, edge2};
  endfunction

  function automatic logic exp_edge(input logic [1:0] m, input logic s, input logic p);
    case (m)
      2'b01:   return s ^ p;
      2'b10:   return p & ~s;
      2'b11:   return s & ~p;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    for (int c = 0; c < 3; c++) begin
      m_mq[c] <= mode_of(c);
      if (rst) begin
        m_s1[c] <= 1'b1; m_s2[c] <= 1'b1; m_pv[c] <= 1'b1;
        m_flag[c] <= 1'b0; m_irq[c] <= 1'b0;
      end else begin
        logic e;
        e = (mode_of(c) == m_mq[c]) && exp_edge(mode_of(c), m_s2[c], m_pv[c]);
        m_s1[c] <= pin[c];
        m_s2[c] <= m_s1[c];
        m_pv[c] <= m_s2[c];
        if (e) m_flag[c] <= 1'b1;
        else if (clr[c] || ack[c]) m_flag[c] <= 1'b0;
        m_irq[c] <= gie && mask[c] && ((mode_of(c) == 2'b00) ? ~m_s2[c] : m_flag[c]);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (run) begin
      chk("R2 model flag_o", flag_o, m_flag);
      chk("R7 model irq_o", irq_o, m_irq);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; pin = 3'b111; mode0 = 2'b11; mode1 = 2'b11; edge2 = 1'b0;
    mask = 3'b111; gie = 1'b1; clr = '0; ack = '0;
    cyc(4);
    rst = 1'b0;
    chk("R1 flag after reset", flag_o, 3'b000);
    chk("R1 irq after reset", irq_o, 3'b000);
    cyc(1);
    run = 1'b1;
    chk("R1 first cycle flag", flag_o, 3'b000);
    cyc(2);

    // rise mode on ch0: falling change ignored, rising change latched
    pin[0] = 1'b0; cyc(4);
    chk("R5 fall ignored in rise mode", flag_o[0], 1'b0);
    pin[0] = 1'b1; cyc(2);
    chk("R2 flag not yet set", flag_o[0], 1'b0);
    cyc(1);
    chk("R2 flag on third edge", flag_o[0], 1'b1);
    chk("R7 irq one cycle later", irq_o[0], 1'b0);
    cyc(1);
    chk("R7 irq follows flag", irq_o[0], 1'b1);
    clr[0] = 1'b1; cyc(1); clr[0] = 1'b0;
    chk("R8 clear strobe", flag_o[0], 1'b0);
    cyc(1);
    chk("R8 irq drops after clear", irq_o[0], 1'b0);

    // level mode on ch1
    mode1 = 2'b00; pin[1] = 1'b0; cyc(2);
    chk("R3 level not yet", irq_o[1], 1'b0);
    cyc(1);
    chk("R3 level request", irq_o[1], 1'b1);
    chk("R3 level sets no flag", flag_o[1], 1'b0);
    clr[1] = 1'b1; ack[1] = 1'b1; cyc(1); clr[1] = 1'b0; ack[1] = 1'b0;
    chk("R3 clear has no effect on level", irq_o[1], 1'b1);
    pin[1] = 1'b1; cyc(3);
    chk("R3 level request drops", irq_o[1], 1'b0);

    // ch2 single-period pulse, falling select
    pin[2] = 1'b0; cyc(1); pin[2] = 1'b1; cyc(2);
    chk("R10 one period pulse captured", flag_o[2], 1'b1);
    ack[2] = 1'b1; cyc(1); ack[2] = 1'b0;
    chk("R8 acknowledge clears", flag_o[2], 1'b0);
    edge2 = 1'b1; cyc(3);
    pin[2] = 1'b0; cyc(4);
    chk("R6 fall ignored with rise select", flag_o[2], 1'b0);
    pin[2] = 1'b1; cyc(3);
    chk("R6 rise captured", flag_o[2], 1'b1);
    ack[2] = 1'b1; cyc(1); ack[2] = 1'b0;

    // any-change mode, edge beats clear
    mode0 = 2'b01; cyc(2);
    pin[0] = 1'b0; cyc(2);
    clr[0] = 1'b1; cyc(1); clr[0] = 1'b0;
    chk("R8 edge wins over clear", flag_o[0], 1'b1);
    clr[0] = 1'b1; cyc(1); clr[0] = 1'b0;
    chk("R8 clear after", flag_o[0], 1'b0);
    pin[0] = 1'b1; cyc(3);
    chk("R4 any change rising", flag_o[0], 1'b1);
    cyc(1);

    // gating
    gie = 1'b0; cyc(1);
    chk("R7 global enable gates", irq_o[0], 1'b0);
    chk("R7 flag kept when gated", flag_o[0], 1'b1);
    gie = 1'b1; mask[0] = 1'b0; cyc(1);
    chk("R7 mask gates", irq_o[0], 1'b0);
    mask[0] = 1'b1; cyc(1);
    chk("R7 request returns", irq_o[0], 1'b1);
    clr[0] = 1'b1; cyc(1); clr[0] = 1'b0;

    // mode change in the edge cycle suppresses detection
    mode0 = 2'b11; pin[0] = 1'b0; cyc(4);
    clr[0] = 1'b1; cyc(1); clr[0] = 1'b0;
    pin[0] = 1'b1; cyc(2);
    mode0 = 2'b01; cyc(2);
    chk("R9 edge suppressed on mode change", flag_o[0], 1'b0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      for (int c = 0; c < 3; c++) begin
        if ($urandom_range(7) == 0) pin[c] = ~pin[c];
        clr[c] = ($urandom_range(15) == 0);
        ack[c] = ($urandom_range(15) == 0);
      end
      if ($urandom_range(63) == 0) mode0 = 2'($urandom_range(3));
      if ($urandom_range(63) == 0) mode1 = 2'($urandom_range(3));
      if ($urandom_range(63) == 0) edge2 = ~edge2;
      if ($urandom_range(31) == 0) gie = ~gie;
      if ($urandom_range(31) == 0) mask = 3'($urandom_range(7));
    end
    cyc(1);
    run = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule